// File: doc/BRIEF.md
# Folded Symmetric FIR Pre-Add Front End

This block sits in front of the coefficient multipliers of a 16-tap FIR filter. Samples enter a forward chain of delay stages. The far end of that chain turns back into a reverse chain of the same number of stages. Every forward tap is matched with a reverse tap that lies at the mirror position of the filter. The two values are combined in a small pre-add unit, so that one shared coefficient can serve both taps. On each clock the block presents one pre-added operand per tap pair (eight with the default build), ready to be multiplied.

Each delay stage holds between 1 and 16 samples. This lets a stream that carries several interleaved data sets be filtered without splitting it first, because one stage then spans exactly one sample of every set. The same setting supports decimated operation, where the output is read once every N samples. The fold point at the turn-around can be moved back by one stage. This gives an odd tap count, in which the centre tap pairs with itself. Each pre-add unit can add its two operands, subtract the forward operand from the reverse one, or zero either operand. These options cover even-symmetric, odd-symmetric and asymmetric coefficient sets.

Top module: `sym_fold_preadd`

## Requirements
- R1: With `cfgSub`=0 and both zero flags low, pair k outputs A+B. A is forward tap k and B is reverse tap NUM_PAIRS-1-k, both read as signed two's complement.
- R2: With `cfgSub`=1 and both zero flags low, pair k outputs B−A.
- R3: `cfgZeroA`=1 replaces A with 0 and `cfgZeroB`=1 replaces B with 0, in every pair. With both flags high, every pair outputs 0.
- R4: Each pair result is DATA_W+1 bits of signed two's complement and never wraps. With DATA_W=8: (−128)+(−128) gives −256, and 127−(−128) gives 255.
- R5: The 4-bit `cfgLen` field sets the length of every stage to `cfgLen`+1 samples (0 means 1, 15 means 16). Forward tap k is the sample accepted (k+1)·L−1 samples before the newest one. A tap reaching before the first sample after reset reads 0.
- R6: With `cfgOdd`=0 (even tap count), the output of the last forward stage feeds the first reverse stage. Reverse tap j is then the sample (NUM_PAIRS+1+j)·L−1 samples before the newest one.
- R7: With `cfgOdd`=1 (odd tap count), the input of the last forward stage feeds the first reverse stage. Reverse tap j is then the sample (NUM_PAIRS+j)·L−1 samples before the newest one, so the centre tap pairs with itself.
- R8: The stages shift only on a clock with `validIn` high. While `validIn` stays low, changes on `dataIn` have no effect, and the outputs hold as long as the pre-add controls are unchanged.
- R9: A sample accepted at edge e is reflected in `preAdd` after edge e+1. `outValid` is high for exactly the cycle after edge e+1.
- R10: A new `cfgLen` or `cfgOdd` value has no effect while `validIn` is low. It takes effect with the next accepted sample, without clearing the stored contents.
- R11: A synchronous reset clears all stage contents, `preAdd` and `outValid` to zero, and sets the stage length back to 1 in the even fold.
- R12: `cfgSub`, `cfgZeroA` and `cfgZeroB` act at the next clock edge whether or not a sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Accept `dataIn` and shift all stages |
| dataIn | input | DATA_W | Signed input sample |
| cfgSub | input | 1 | 0: A+B, 1: B−A |
| cfgZeroA | input | 1 | Force forward operand to zero |
| cfgZeroB | input | 1 | Force reverse operand to zero |
| cfgLen | input | 4 | Stage length minus one |
| cfgOdd | input | 1 | 0: even tap fold, 1: odd tap fold |
| preAdd | output | NUM_PAIRS*(DATA_W+1) | Pair k at bits [k*(DATA_W+1) +: DATA_W+1], signed |
| outValid | output | 1 | `preAdd` reflects a newly accepted sample |

## Verification
The bench builds the block with its defaults: 8-bit samples and eight tap pairs, which is the full 16-tap folded structure. With that build, full-scale operands reach both ends of the 9-bit result range. Forcing stage lengths of 1 and 16 puts the deepest reverse tap 255 samples back. Random phases run each fold mode long enough to fill both chains, and the reference model is a plain sample history indexed by tap delay.

// File: rtl/sym_fold_pkg.sv
package sym_fold_pkg;
  // Width of the stage-length field; stage depth follows from it.
  localparam int LEN_W   = 4;
  localparam int MAX_LEN = 1 << LEN_W;

  typedef enum logic {
    OP_ADD     = 1'b0,
    OP_REV_SUB = 1'b1
  } aluOp_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             shiftEn;
    logic [LEN_W-1:0] lenSel;
    logic             foldOdd;
    aluOp_e           aluOp;
    logic             zeroA;
    logic             zeroB;
  } strobe_t;
endpackage

// File: rtl/sym_fold_stage.sv
// One programmable-length delay stage: a fixed-depth shift memory
// read at a selectable position.
module sym_fold_stage #(
  parameter  int WIDTH = 8,
  parameter  int DEPTH = 16,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shiftEn,
  input  logic [SEL_W-1:0] tapSel,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (shiftEn) begin
      mem[0] <= din;
      for (int i = 1; i < DEPTH; i++) mem[i] <= mem[i-1];
    end
  end

  // Position tapSel holds the sample pushed tapSel+1 shifts ago.
  assign dout = mem[tapSel];
endmodule

// File: rtl/sym_fold_alu.sv
// Pre-add unit: A+B or B-A, with either operand forced to zero.
module sym_fold_alu
  import sym_fold_pkg::*;
#(
  parameter  int WIDTH = 8,
  localparam int RES_W = WIDTH + 1
) (
  input  logic [WIDTH-1:0]        opA,
  input  logic [WIDTH-1:0]        opB,
  input  aluOp_e                  aluOp,
  input  logic                    zeroA,
  input  logic                    zeroB,
  output logic signed [RES_W-1:0] result
);
  logic signed [RES_W-1:0] extA;
  logic signed [RES_W-1:0] extB;

  always_comb begin
    extA = zeroA ? '0 : RES_W'($signed(opA));
    extB = zeroB ? '0 : RES_W'($signed(opB));
    if (aluOp == OP_REV_SUB) result = extB - extA;
    else                     result = extA + extB;
  end
endmodule

// File: rtl/sym_fold_ctrl.sv
// Control: holds the stage length and fold mode, forms strobes and
// the output-valid pipeline.
module sym_fold_ctrl
  import sym_fold_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             validIn,
  input  logic             cfgSub,
  input  logic             cfgZeroA,
  input  logic             cfgZeroB,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgOdd,
  output strobe_t          strobe,
  output logic             outValid
);
  logic [LEN_W-1:0] lenReg;
  logic             oddReg;
  logic             validQ;
  logic             outValidQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      lenReg    <= '0;
      oddReg    <= 1'b0;
      validQ    <= 1'b0;
      outValidQ <= 1'b0;
    end else begin
      validQ    <= validIn;
      outValidQ <= validQ;
      if (validIn) begin
        lenReg <= cfgLen;
        oddReg <= cfgOdd;
      end
    end
  end

  // A sample shifts with the geometry given alongside it; between
  // samples the held geometry applies.
  always_comb begin
    strobe.shiftEn = validIn;
    strobe.lenSel  = validIn ? cfgLen : lenReg;
    strobe.foldOdd = validIn ? cfgOdd : oddReg;
    strobe.aluOp   = aluOp_e'(cfgSub);
    strobe.zeroA   = cfgZeroA;
    strobe.zeroB   = cfgZeroB;
  end

  assign outValid = outValidQ;
endmodule

// File: rtl/sym_fold_dp.sv
// Datapath: forward chain, fold, reverse chain, pre-add units and
// registered pair outputs.
module sym_fold_dp
  import sym_fold_pkg::*;
#(
  parameter  int DATA_W    = 8,
  parameter  int NUM_PAIRS = 8,
  localparam int OUT_W     = DATA_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    strobe,
  input  logic [DATA_W-1:0]          dataIn,
  output logic [NUM_PAIRS*OUT_W-1:0] preAdd
);
  logic [DATA_W-1:0] fwdIn  [NUM_PAIRS];
  logic [DATA_W-1:0] fwdOut [NUM_PAIRS];
  logic [DATA_W-1:0] revIn  [NUM_PAIRS];
  logic [DATA_W-1:0] revOut [NUM_PAIRS];
  logic signed [OUT_W-1:0] aluRes [NUM_PAIRS];
  logic [OUT_W-1:0]        pairQ  [NUM_PAIRS];

  // Forward chain
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_fwd
    if (k == 0) begin : g_head
      assign fwdIn[k] = dataIn;
    end else begin : g_link
      assign fwdIn[k] = fwdOut[k-1];
    end
    sym_fold_stage #(.WIDTH(DATA_W), .DEPTH(MAX_LEN)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .shiftEn(strobe.shiftEn),
      .tapSel (strobe.lenSel),
      .din    (fwdIn[k]),
      .dout   (fwdOut[k])
    );
  end

  // Reverse chain; the odd fold skips the last forward stage.
  for (genvar j = 0; j < NUM_PAIRS; j++) begin : g_rev
    if (j == 0) begin : g_fold
      assign revIn[j] = strobe.foldOdd ? fwdIn[NUM_PAIRS-1] : fwdOut[NUM_PAIRS-1];
    end else begin : g_link
      assign revIn[j] = revOut[j-1];
    end
    sym_fold_stage #(.WIDTH(DATA_W), .DEPTH(MAX_LEN)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .shiftEn(strobe.shiftEn),
      .tapSel (strobe.lenSel),
      .din    (revIn[j]),
      .dout   (revOut[j])
    );
  end

  // Pair forward tap k with the mirrored reverse tap
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    sym_fold_alu #(.WIDTH(DATA_W)) u_alu (
      .opA   (fwdOut[k]),
      .opB   (revOut[NUM_PAIRS-1-k]),
      .aluOp (strobe.aluOp),
      .zeroA (strobe.zeroA),
      .zeroB (strobe.zeroB),
      .result(aluRes[k])
    );

    always_ff @(posedge clk) begin
      if (rst) pairQ[k] <= '0;
      else     pairQ[k] <= aluRes[k];
    end

    assign preAdd[k*OUT_W +: OUT_W] = pairQ[k];
  end
endmodule

// File: rtl/sym_fold_preadd.sv
// Top: folded symmetric pre-add front end.
module sym_fold_preadd
  import sym_fold_pkg::*;
#(
  parameter  int DATA_W    = 8,
  parameter  int NUM_PAIRS = 8,
  localparam int OUT_W     = DATA_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       validIn,
  input  logic [DATA_W-1:0]          dataIn,
  input  logic                       cfgSub,
  input  logic                       cfgZeroA,
  input  logic                       cfgZeroB,
  input  logic [LEN_W-1:0]           cfgLen,
  input  logic                       cfgOdd,
  output logic [NUM_PAIRS*OUT_W-1:0] preAdd,
  output logic                       outValid
);
  strobe_t strobe;

  sym_fold_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .validIn (validIn),
    .cfgSub  (cfgSub),
    .cfgZeroA(cfgZeroA),
    .cfgZeroB(cfgZeroB),
    .cfgLen  (cfgLen),
    .cfgOdd  (cfgOdd),
    .strobe  (strobe),
    .outValid(outValid)
  );

  sym_fold_dp #(.DATA_W(DATA_W), .NUM_PAIRS(NUM_PAIRS)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .dataIn(dataIn),
    .preAdd(preAdd)
  );
endmodule

// File: rtl/sym_fold_preadd_chk.sv
// Property checker bound to the top.
module sym_fold_preadd_chk #(
  parameter  int DATA_W    = 8,
  parameter  int NUM_PAIRS = 8,
  localparam int OUT_W     = DATA_W + 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       validIn,
  input logic                       cfgSub,
  input logic                       cfgZeroA,
  input logic                       cfgZeroB,
  input logic [NUM_PAIRS*OUT_W-1:0] preAdd,
  input logic                       outValid
);
  AST_VALID_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
    validIn |=> ##1 outValid); // R9

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> ##1 !outValid); // R9

  AST_BOTH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfgZeroA && cfgZeroB) |=> (preAdd == '0)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !validIn && !$past(validIn) && $stable(cfgSub)
     && $stable(cfgZeroA) && $stable(cfgZeroB)) |=> $stable(preAdd)); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (preAdd == '0 && !outValid)); // R11
endmodule

bind sym_fold_preadd sym_fold_preadd_chk #(.DATA_W(DATA_W), .NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .validIn (validIn),
  .cfgSub  (cfgSub),
  .cfgZeroA(cfgZeroA),
  .cfgZeroB(cfgZeroB),
  .preAdd  (preAdd),
  .outValid(outValid)
);

// File: tb/sym_fold_preadd_tb.sv
`timescale 1ns/1ps
module sym_fold_preadd_tb;
  localparam int DATA_W    = 8;
  localparam int NUM_PAIRS = 8;
  localparam int OUT_W     = DATA_W + 1;
  localparam int LEN_W     = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validIn = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic cfgSub = 1'b0, cfgZeroA = 1'b0, cfgZeroB = 1'b0, cfgOdd = 1'b0;
  logic [LEN_W-1:0] cfgLen = '0;
  logic [NUM_PAIRS*OUT_W-1:0] preAdd;
  logic outValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic signed [DATA_W-1:0] histBuf [4096];
  int histCnt = 0;
  int aLen = 1;
  bit aOdd = 1'b0;

  always #2.5 clk = ~clk;

  sym_fold_preadd #(.DATA_W(DATA_W), .NUM_PAIRS(NUM_PAIRS)) u_dut (
    .clk(clk), .rst(rst), .validIn(validIn), .dataIn(dataIn),
    .cfgSub(cfgSub), .cfgZeroA(cfgZeroA), .cfgZeroB(cfgZeroB),
    .cfgLen(cfgLen), .cfgOdd(cfgOdd), .preAdd(preAdd), .outValid(outValid)
  );

  function automatic logic signed [OUT_W-1:0] histAt(int d);
    int idx = histCnt - 1 - d;
    if (idx < 0) return '0;
    return OUT_W'(histBuf[idx]);
  endfunction

  // Expected pair value from tap delays (R1..R7)
  function automatic logic signed [OUT_W-1:0] expPair(int k);
    int rj = NUM_PAIRS - 1 - k;
    int fd = (k + 1) * aLen - 1;
    int rd = aOdd ? (NUM_PAIRS + rj) * aLen - 1 : (NUM_PAIRS + 1 + rj) * aLen - 1;
    logic signed [OUT_W-1:0] a = cfgZeroA ? '0 : histAt(fd);
    logic signed [OUT_W-1:0] b = cfgZeroB ? '0 : histAt(rd);
    return cfgSub ? b - a : a + b;
  endfunction

  function automatic logic signed [OUT_W-1:0] gotPair(int k);
    return $signed(preAdd[k*OUT_W +: OUT_W]);
  endfunction

  task automatic checkAll(input string tag);
    bit bad = 1'b0;
    checks++;
    for (int k = 0; k < NUM_PAIRS; k++) begin
      if (!bad && gotPair(k) !== expPair(k)) begin
        bad = 1'b1;
        $display("FAIL %s pair %0d actual %0d expected %0d", tag, k, gotPair(k), expPair(k));
      end
    end
    if (bad) errors++;
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    validIn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    histCnt = 0;
    aLen = 1;
    aOdd = 1'b0;
  endtask

  // Starts and ends at a falling edge.
  task automatic push(input logic [DATA_W-1:0] x, input bit latChk);
    validIn = 1'b1;
    dataIn = x;
    aLen = int'(cfgLen) + 1;
    aOdd = cfgOdd;
    @(posedge clk);
    @(negedge clk);
    validIn = 1'b0;
    dataIn = DATA_W'($urandom);  // ignored while idle (R8)
    histBuf[histCnt] = $signed(x);
    histCnt++;
    if (latChk) checkVal("R9 outValid after first edge", int'(outValid), 0);
    @(posedge clk);
    @(negedge clk);
    if (latChk) checkVal("R9 outValid after second edge", int'(outValid), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R9 actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0F01));
    doReset();
    checkVal("R11 outValid after reset", int'(outValid), 0);
    checkVal("R11 preAdd cleared", int'(preAdd == '0), 1);

    // Full negative sum, length 1, even fold
    cfgLen = '0;
    push(8'h80, 1'b1);
    repeat (2*NUM_PAIRS - 1) push(8'h80, 1'b0);
    checkAll("R4 R1 full negative sum");

    cfgSub = 1'b1;                        // no sample accepted
    @(posedge clk); @(negedge clk);
    checkAll("R12 R2 op change without sample");
    cfgZeroA = 1'b1;
    @(posedge clk); @(negedge clk);
    checkAll("R12 R3 zero A operand");
    cfgZeroB = 1'b1;
    @(posedge clk); @(negedge clk);
    checkAll("R3 both operands zero");
    checkVal("R3 all pairs zero", int'(preAdd == '0), 1);

    // Full positive difference: forward taps -128, reverse taps 127
    doReset();
    cfgSub = 1'b0; cfgZeroA = 1'b0; cfgZeroB = 1'b0; cfgLen = '0; cfgOdd = 1'b0;
    repeat (NUM_PAIRS) push(8'h7F, 1'b0);
    repeat (NUM_PAIRS) push(8'h80, 1'b0);
    cfgSub = 1'b1;
    @(posedge clk); @(negedge clk);
    checkAll("R4 R2 full positive difference");
    checkVal("R4 difference value", int'(gotPair(0)), 255);

    // Random phases across fold modes and lengths
    for (int ph = 0; ph < 6; ph++) begin
      int n;
      doReset();
      cfgOdd = ph[0];
      cfgLen = (ph == 0) ? 4'd0 : (ph == 1) ? 4'd15 : LEN_W'($urandom);
      n = 2 * NUM_PAIRS * (int'(cfgLen) + 1) + 12;
      for (int i = 0; i < n; i++) begin
        cfgSub   = 1'($urandom);
        cfgZeroA = ($urandom % 8) == 0;
        cfgZeroB = ($urandom % 8) == 0;
        push(DATA_W'($urandom), 1'b0);
        if (cfgOdd) checkAll("R7 R5 odd fold");
        else        checkAll("R6 R5 even fold");
      end
      // Idle with new geometry and changing data: nothing moves
      cfgLen = LEN_W'($urandom);
      cfgOdd = ~cfgOdd;
      repeat (4) begin
        dataIn = DATA_W'($urandom);
        @(posedge clk); @(negedge clk);
      end
      checkAll("R8 R10 idle hold");
    end

    // Length change applies with the next sample, no flush
    doReset();
    cfgSub = 1'b0; cfgZeroA = 1'b0; cfgZeroB = 1'b0; cfgOdd = 1'b0; cfgLen = 4'd2;
    repeat (40) push(DATA_W'($urandom), 1'b0);
    checkAll("R10 before length change");
    cfgLen = 4'd5;
    cfgZeroB = 1'b1;
    push(DATA_W'($urandom), 1'b0);
    checkVal("R10 forward tap uses new length", int'(gotPair(0)), int'(expPair(0)));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule